// File: doc/BRIEF.md
# Program Counter and Next-Address Unit

This block owns the program counter of a simple in-order processor front end and chooses its next value on every clock. The counter drives the instruction memory address directly. The same cycle's incremented address is also brought out so that neighbouring logic can use it. Each clock the counter moves to one of three addresses: the next sequential word, a PC-relative branch destination, or a pseudo-direct jump destination.

Decode logic supplies plain control pins: a branch request, a jump request, the ALU equality flag, the 16-bit immediate and the 26-bit jump field of the current instruction. No valid/ready handshake applies. The unit advances unconditionally on every clock, so it never exerts back-pressure and never accepts any. A synchronous reset returns the counter to address zero.

Top module: `fetch_pc_unit`

## Requirements
- R1: When `rst` is 1 at a rising edge of `clk`, `pc_addr` is 0x00000000 after that edge, whatever the other inputs are.
- R2: When `jump_sel` is 0 and `branch_sel` and `zero_flag` are not both 1, `pc_addr` after the edge equals `pc_addr` before it plus 4.
- R3: When `jump_sel` is 0 and both `branch_sel` and `zero_flag` are 1, `pc_addr` after the edge equals old `pc_addr` + 4 + (sign-extended `imm16` multiplied by 4).
- R4: Bit 15 of `imm16` is the sign bit. A negative immediate gives a backward branch, for example -4 moves the PC to old PC + 4 - 16.
- R5: A branch request with `zero_flag` at 0 is not taken, and the PC advances by 4.
- R6: When `jump_sel` is 1, `pc_addr` after the edge is {old `pc_addr`[31:28], `jtarget`[25:0], 2'b00}.
- R7: When `jump_sel` is 1, the values of `branch_sel`, `zero_flag` and `imm16` have no effect on the next PC.
- R8: Bits [1:0] of `pc_addr` are always 0 once reset has been applied.
- R9: `pc_plus4` equals `pc_addr` + 4 in every cycle.
- R10: All address arithmetic wraps modulo 2^32. A backward branch from address 0 reaches 0xFFFFFFFC, and the following sequential step from there returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| branch_sel | input | 1 | Current instruction is a conditional branch |
| jump_sel | input | 1 | Current instruction is a jump; has priority over the branch |
| zero_flag | input | 1 | ALU equality result used by the branch condition |
| imm16 | input | 16 | Signed branch offset in words |
| jtarget | input | 26 | Word index of the jump target inside the current 256 MB region |
| pc_addr | output | 32 | Current program counter, used as the instruction memory address |
| pc_plus4 | output | 32 | Current program counter plus 4 |

## Verification
The checker assumes that `rst` is held high from time zero through the first rising edge. It also assumes that every control and data input carries a known value on each edge where reset is low. The bench meets both conditions: it raises reset before the clock starts, and it changes inputs only on falling edges, always to defined values. The stimulus includes a backward branch from address zero and jumps issued while the branch condition is true. These cases reach the wrap-around and the jump-priority rules, which an ordinary forward instruction stream would never touch.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  localparam int unsigned ADDR_W      = 32;
  localparam int unsigned IMM_W       = 16;
  localparam int unsigned TGT_W       = 26;
  localparam int unsigned WORD_BYTES  = 4;
  localparam int unsigned WORD_SHIFT  = $clog2(WORD_BYTES);
  localparam int unsigned REGION_W    = ADDR_W - TGT_W - WORD_SHIFT;

  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_JUMP   = 2'd2
  } pc_src_e;

endpackage

// File: rtl/pc_incr.sv
module pc_incr #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] seq_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  always_comb begin
    seq_o = pc_i + STEP;
  end
endmodule

// File: rtl/branch_target.sv
module branch_target #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned IMM_W      = 16,
  parameter int unsigned WORD_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] seq_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam int unsigned EXT_W = ADDR_W - IMM_W - WORD_SHIFT;

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset   = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, {WORD_SHIFT{1'b0}}};
    target_o = seq_i + offset;
  end
endmodule

// File: rtl/jump_target.sv
module jump_target #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned TGT_W      = 26,
  parameter int unsigned WORD_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [TGT_W-1:0]  tgt_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam int unsigned REGION_W = ADDR_W - TGT_W - WORD_SHIFT;

  always_comb begin
    target_o = {pc_i[ADDR_W-1 -: REGION_W], tgt_i, {WORD_SHIFT{1'b0}}};
  end
endmodule

// File: rtl/next_pc_mux.sv
module next_pc_mux
  import fetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              branch_sel_i,
  input  logic              jump_sel_i,
  input  logic              zero_i,
  input  logic [ADDR_W-1:0] seq_i,
  input  logic [ADDR_W-1:0] branch_i,
  input  logic [ADDR_W-1:0] jump_i,
  output logic [ADDR_W-1:0] next_o
);
  pc_src_e src;

  always_comb begin
    if (jump_sel_i)                  src = SRC_JUMP;
    else if (branch_sel_i && zero_i) src = SRC_BRANCH;
    else                             src = SRC_SEQ;
  end

  always_comb begin
    unique case (src)
      SRC_JUMP:   next_o = jump_i;
      SRC_BRANCH: next_o = branch_i;
      default:    next_o = seq_i;
    endcase
  end
endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
  import fetch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              branch_sel,
  input  logic              jump_sel,
  input  logic              zero_flag,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [TGT_W-1:0]  jtarget,
  output logic [ADDR_W-1:0] pc_addr,
  output logic [ADDR_W-1:0] pc_plus4
);
  addr_t pc_q;
  addr_t seq_addr;
  addr_t br_addr;
  addr_t jmp_addr;
  addr_t next_addr;

  pc_incr #(
    .ADDR_W     (ADDR_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_incr (
    .pc_i  (pc_q),
    .seq_o (seq_addr)
  );

  branch_target #(
    .ADDR_W     (ADDR_W),
    .IMM_W      (IMM_W),
    .WORD_SHIFT (WORD_SHIFT)
  ) u_branch (
    .seq_i    (seq_addr),
    .imm_i    (imm16),
    .target_o (br_addr)
  );

  jump_target #(
    .ADDR_W     (ADDR_W),
    .TGT_W      (TGT_W),
    .WORD_SHIFT (WORD_SHIFT)
  ) u_jump (
    .pc_i     (pc_q),
    .tgt_i    (jtarget),
    .target_o (jmp_addr)
  );

  next_pc_mux #(
    .ADDR_W (ADDR_W)
  ) u_mux (
    .branch_sel_i (branch_sel),
    .jump_sel_i   (jump_sel),
    .zero_i       (zero_flag),
    .seq_i        (seq_addr),
    .branch_i     (br_addr),
    .jump_i       (jmp_addr),
    .next_o       (next_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= next_addr;
  end

  assign pc_addr  = pc_q;
  assign pc_plus4 = seq_addr;
endmodule

// File: rtl/fetch_pc_checker.sv
module fetch_pc_checker
  import fetch_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              branch_sel,
  input logic              jump_sel,
  input logic              zero_flag,
  input logic [IMM_W-1:0]  imm16,
  input logic [TGT_W-1:0]  jtarget,
  input logic [ADDR_W-1:0] pc_addr,
  input logic [ADDR_W-1:0] pc_plus4
);
  localparam int unsigned EXT_W = ADDR_W - IMM_W - WORD_SHIFT;

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (pc_addr == '0));

  assert_sequential_R2: assert property (@(posedge clk) disable iff (rst)
    (!jump_sel && !(branch_sel && zero_flag)) |=>
      (pc_addr == $past(pc_addr) + ADDR_W'(WORD_BYTES)));

  assert_branch_taken_R3: assert property (@(posedge clk) disable iff (rst)
    (!jump_sel && branch_sel && zero_flag) |=>
      (pc_addr == $past(pc_addr) + ADDR_W'(WORD_BYTES) +
        {{EXT_W{$past(imm16[IMM_W-1])}}, $past(imm16), {WORD_SHIFT{1'b0}}}));

  // Covers R6 and R7: the jump result ignores the branch inputs.
  assert_jump_R6: assert property (@(posedge clk) disable iff (rst)
    jump_sel |=>
      (pc_addr == {$past(pc_addr[ADDR_W-1 -: REGION_W]), $past(jtarget),
                   {WORD_SHIFT{1'b0}}}));

  assert_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    pc_addr[WORD_SHIFT-1:0] == '0);

  assert_plus4_R9: assert property (@(posedge clk) disable iff (rst)
    pc_plus4 == pc_addr + ADDR_W'(WORD_BYTES));
endmodule

bind fetch_pc_unit fetch_pc_checker i_chk (.*);

// File: tb/test_fetch_pc_unit.sv
`timescale 1ns/1ps
module test_fetch_pc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        branch_sel = 1'b0;
  logic        jump_sel = 1'b0;
  logic        zero_flag = 1'b0;
  logic [15:0] imm16 = '0;
  logic [25:0] jtarget = '0;
  logic [31:0] pc_addr;
  logic [31:0] pc_plus4;

  int checks = 0;
  int errors = 0;
  logic [31:0] model_pc = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fetch_pc_unit i_fetch_pc_unit (
    .clk(clk), .rst(rst), .branch_sel(branch_sel), .jump_sel(jump_sel),
    .zero_flag(zero_flag), .imm16(imm16), .jtarget(jtarget),
    .pc_addr(pc_addr), .pc_plus4(pc_plus4)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, advance model, compare at next fall.
  task automatic step(string req, bit r, bit b, bit j, bit z,
                      logic [15:0] imm, logic [25:0] tgt);
    rst = r; branch_sel = b; jump_sel = j; zero_flag = z;
    imm16 = imm; jtarget = tgt;
    @(posedge clk);
    if (r)          model_pc = 32'h0;
    else if (j)     model_pc = {model_pc[31:28], tgt, 2'b00};
    else if (b & z) model_pc = model_pc + 32'd4 + 32'(int'($signed(imm)) * 4);
    else            model_pc = model_pc + 32'd4;
    @(negedge clk);
    check(req, pc_addr, model_pc);
    check("R9", pc_plus4, model_pc + 32'd4);
    check("R8", {30'd0, pc_addr[1:0]}, 32'd0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step("R1", 1, 1, 1, 1, 16'h0005, 26'h3FFFFFF);
    check("R1", pc_addr, 32'h0);
    step("R2", 0, 0, 0, 0, 16'h0000, 26'h0);
    step("R2", 0, 0, 0, 0, 16'h7FFF, 26'h1);
    step("R2", 0, 0, 0, 1, 16'h0040, 26'h0);     // zero alone: sequential
    step("R5", 0, 1, 0, 0, 16'h0005, 26'h0);     // branch not taken
    step("R3", 0, 1, 0, 1, 16'h0003, 26'h0);     // forward branch
    step("R4", 0, 1, 0, 1, 16'hFFFC, 26'h0);     // backward branch by -4
    step("R6", 0, 0, 1, 0, 16'h0000, 26'h0ABCDEF);
    check("R6", pc_addr, 32'h02AF37BC);
    step("R7", 0, 1, 1, 1, 16'h0064, 26'h0000010);
    check("R7", pc_addr, 32'h00000040);
    step("R7", 0, 1, 1, 0, 16'h8000, 26'h0000011);
    step("R1", 1, 0, 0, 0, 16'h0, 26'h0);
    step("R10", 0, 1, 0, 1, 16'hFFFE, 26'h0);    // 0 + 4 - 8
    check("R10", pc_addr, 32'hFFFFFFFC);
    step("R10", 0, 0, 0, 0, 16'h0, 26'h0);
    check("R10", pc_addr, 32'h0);
    step("R10", 0, 1, 0, 1, 16'hFFFE, 26'h0);
    step("R6", 0, 0, 1, 0, 16'h0, 26'h0000001);  // region bits kept
    check("R6", pc_addr, 32'hF0000004);
    for (int k = 0; k < 300; k++) begin
      logic [31:0] rv;
      rv = $urandom;
      step("R3", (rv[7:0] == 8'h00), rv[8], (rv[11:9] == 3'd0), rv[12],
           rv[31:16], {rv[15:0], rv[25:16]});
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule